// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst. A load cycle captures an external start address. Each following advance cycle moves the two low address bits to the next beat. A static mode input chooses the order. In linear order the offset counts up from the start and wraps modulo four. In interleaved order the start offset is XORed with the beat count. Address bits above the two-bit offset are passed through from the captured start address and never change during a burst.

The block sits in front of a memory array or a burst-capable bus agent. One start address is presented per burst, and the block supplies the remaining three beat addresses with no extra address traffic. An active-low clock enable can freeze the sequencer for any number of cycles. The burst address is driven from registers, so it is valid in the cycle after the clock edge that loaded or advanced the sequencer.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is applied, and after it is released, `burstAddr` is 0 until the first load.
- R2: On a clock edge with `clkEnN`=0 and `advLoadN`=0, the sequencer captures `extAddr` and restarts the beat count at 0. From the next cycle `burstAddr` equals `extAddr`.
- R3: On a clock edge with `clkEnN`=0 and `advLoadN`=1, the beat count increases by one, modulo 4.
- R4: With `interleave`=0, the low two bits of `burstAddr` are (start offset + beat count) mod 4. A start offset of 1 gives the order 1,2,3,0.
- R5: With `interleave`=1, the low two bits of `burstAddr` are the start offset XOR the beat count. A start offset of 1 gives the order 1,0,3,2.
- R6: On a clock edge with `clkEnN`=1, the sequencer keeps its state. `burstAddr` is unchanged whatever `advLoadN` and `extAddr` are.
- R7: After four advances, `burstAddr` returns to the start address. Bits above bit 1 never change on an advance.
- R8: A load in the middle of a burst discards the old burst. The new start address is output with beat count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; 1 freezes the sequencer |
| advLoadN | input | 1 | 0 loads `extAddr`, 1 advances the burst |
| interleave | input | 1 | Static order select: 0 linear, 1 interleaved |
| extAddr | input | ADDR_W | External start address |
| burstAddr | output | ADDR_W | Current beat address |

## Verification
Every load, advance or hold decided at a rising edge shows on `burstAddr` one cycle later, because the only registers are the base address and the beat counter. The driver applies inputs on the falling edge and pushes the value it predicts for the next edge into a queue. The monitor pops and compares that value 1 ns after that rising edge, which is well after the registers settle and before the next falling-edge stimulus. The order bit acts combinationally, so it is changed only before a load, never inside a checked burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clkEnN,
  input  logic        advLoadN,
  output seqStrobes_t strobes
);
  always_comb begin
    strobes.load    = !clkEnN && !advLoadN;
    strobes.advance = !clkEnN &&  advLoadN;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strobes,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int UPPER_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [OFFS_W-1:0] beatCnt;
  logic [OFFS_W-1:0] startOffs;
  logic [OFFS_W-1:0] linOffs;
  logic [OFFS_W-1:0] xorOffs;
  logic [OFFS_W-1:0] curOffs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (strobes.advance) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  assign startOffs = baseAddr[OFFS_W-1:0];
  assign linOffs   = startOffs + beatCnt;

  genvar i;
  generate
    for (i = 0; i < OFFS_W; i++) begin : g_xorBit
      assign xorOffs[i] = startOffs[i] ^ beatCnt[i];
    end
  endgenerate

  assign curOffs   = interleave ? xorOffs : linOffs;
  assign burstAddr = {baseAddr[ADDR_W-1 -: UPPER_W], curOffs};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEnN,
  input  logic              advLoadN,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int OFFS_W = 2;

  seqStrobes_t strobes;

  burst_seq_ctrl ctrl_i (
    .clkEnN   (clkEnN),
    .advLoadN (advLoadN),
    .strobes  (strobes)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .interleave (interleave),
    .extAddr    (extAddr),
    .burstAddr  (burstAddr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clkEnN,
  input logic              advLoadN,
  input logic              interleave,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] burstAddr
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && !advLoadN) |=> (burstAddr == $past(extAddr))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    clkEnN |=> (!$stable(interleave) || $stable(burstAddr))); // R6

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && advLoadN) |=> $stable(burstAddr[ADDR_W-1:2])); // R7

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && advLoadN && !interleave) |=>
      (interleave || burstAddr[1:0] == $past(burstAddr[1:0]) + 2'd1)); // R4

  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkEnN && advLoadN && interleave) |=>
      (!interleave || burstAddr[0] != $past(burstAddr[0]))); // R5

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (burstAddr == '0)); // R1
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .clkEnN     (clkEnN),
  .advLoadN   (advLoadN),
  .interleave (interleave),
  .extAddr    (extAddr),
  .burstAddr  (burstAddr)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clkEnN = 1'b1;
  logic          advLoadN = 1'b1;
  logic          interleave = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] burstAddr;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;

  logic [AW-1:0] expQ[$];
  string         tagQ[$];

  logic [AW-1:0] mBase = '0;
  logic [1:0]    mBeat = '0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clkEnN(clkEnN), .advLoadN(advLoadN),
    .interleave(interleave), .extAddr(extAddr), .burstAddr(burstAddr)
  );

  function automatic logic [AW-1:0] model();
    logic [1:0] offs;
    offs = interleave ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat);
    return {mBase[AW-1:2], offs};
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string tag);
    nChecks++;
    if (burstAddr !== exp) begin
      nBad++;
      $display("FAIL %s: burstAddr=%h expected=%h", tag, burstAddr, exp);
    end
  endtask

  // Driver: applies inputs on the falling edge, predicts the next result.
  task automatic step(input logic ceN, input logic alN,
                      input logic [AW-1:0] a, input string tag);
    clkEnN   = ceN;
    advLoadN = alN;
    extAddr  = a;
    if (!ceN) begin
      if (!alN) begin
        mBase = a;
        mBeat = '0;
      end else begin
        mBeat = mBeat + 2'd1;
      end
    end
    expQ.push_back(model());
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compares one queued item per rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(e, t);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check('0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check('0, "R1 after reset");
    step(1'b1, 1'b1, 17'h0ABCD, "R1 idle after reset");

    // Linear burst from offset 1: 1,2,3,0 then wrap.
    interleave = 1'b0;
    step(1'b0, 1'b0, 17'h12341, "R2 load linear");
    step(1'b0, 1'b1, '0, "R3 R4 beat1");
    step(1'b0, 1'b1, '0, "R4 beat2");
    step(1'b0, 1'b1, '0, "R4 beat3");
    step(1'b0, 1'b1, '0, "R7 wrap linear");

    // Hold with changing inputs.
    step(1'b1, 1'b0, 17'h1FFFF, "R6 hold ignores load");
    step(1'b1, 1'b1, 17'h00002, "R6 hold ignores advance");
    step(1'b0, 1'b1, '0, "R3 resume after hold");

    // Interleaved burst from offset 1: 1,0,3,2.
    interleave = 1'b1;
    step(1'b0, 1'b0, 17'h0F0F1, "R2 load interleaved");
    step(1'b0, 1'b1, '0, "R5 beat1");
    step(1'b0, 1'b1, '0, "R5 beat2");
    step(1'b1, 1'b0, 17'h00000, "R6 hold mid burst");
    step(1'b0, 1'b1, '0, "R5 beat3");
    step(1'b0, 1'b1, '0, "R7 wrap interleaved");

    // Interleaved from offset 3: 3,2,1,0.
    step(1'b0, 1'b0, 17'h1AAAB, "R2 load offs3");
    step(1'b0, 1'b1, '0, "R5 offs3 beat1");
    step(1'b0, 1'b1, '0, "R5 offs3 beat2");
    // Load in the middle of a burst.
    step(1'b0, 1'b0, 17'h05552, "R8 reload mid burst");
    step(1'b0, 1'b1, '0, "R8 beat1 after reload");

    // Linear from offset 2, upper bits fixed through full burst.
    interleave = 1'b0;
    step(1'b0, 1'b0, 17'h1FFFE, "R2 load offs2 linear");
    step(1'b0, 1'b1, '0, "R7 no carry beat1");
    step(1'b0, 1'b1, '0, "R7 no carry beat2");
    step(1'b0, 1'b1, '0, "R4 offs2 beat3");
    step(1'b0, 1'b1, '0, "R7 wrap offs2");
    step(1'b1, 1'b1, '0, "R6 final hold");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule